// File: doc/BRIEF.md
# Sum of Absolute Differences Block Matcher

This block scores how well an 8×8 reference template matches each of the 81 possible placements inside a 16×16 live image. For every placement (u,v), where u is the row shift and v is the column shift, it forms the sum over the template of the absolute pixel differences. The smallest sum marks the best match. A host writes the template through a small load port. A single start pulse then runs a complete search. During the search the block fetches live pixels from an external image buffer through a read port that returns data one cycle after the request.

A bank of 18 processing elements is folded over five passes. Each pass covers two placement rows (u, u+1) and streams the 9 image rows they need. The last pass covers only row u = 8 and streams 8 rows. Each fetched live pixel is broadcast to all elements. Template pixels travel along a shift chain, one element per cycle, so each element sees the template pixel that belongs to its own column shift. Each element keeps only the pixels that fall inside its own window. It passes each pair through three stages: it orders the pair so the larger value comes first, subtracts, and adds the difference to a 22-bit accumulator. After each pass the block emits that pass's scores one per cycle. It also keeps a running minimum and pulses a done signal after the last score.

Top module: `sadm_matcher`

## Requirements
- R1: After a start pulse, all 81 scores are emitted, each equal to the sum over i,j in 0..7 of |live(i+u, j+v) − tpl(i,j)|, with score_idx = u*9 + v.
- R2: Pixels are 16 bits unsigned and scores are 22 bits. A full-scale difference on all 64 pixels gives 4194240 with no wrap.
- R3: The absolute difference is symmetric: a live pixel above the template pixel and one below it by the same amount add the same amount to the score.
- R4: Pass p (0..4) requests the live rows 2p through min(2p+8, 15), row-major, columns 0..15, with pix_addr = row*16 + col and one request per cycle. That is 144 requests per full pass, 128 for the last pass and 704 per search.
- R5: Scores appear with score_valid high, one per cycle, in strictly increasing score_idx: 18 per pass for passes 0..3 and 9 for the last pass.
- R6: done is a single-cycle pulse in the cycle after the score with index 80, and it occurs exactly once per search.
- R7: After done, best_score, best_u and best_v give the smallest score and its offset. On a tie, the lowest index wins.
- R8: Writing ref_data with ref_we at ref_addr = i*8 + j sets template pixel (i,j). The template is kept across searches.
- R9: After reset, busy, score_valid, done and pix_rd are low. While busy is high, start and ref_we are ignored.
- R10: Every pass starts its accumulators from zero, so repeating a search on the same data gives identical scores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search (ignored while busy) |
| ref_we | input | 1 | Template write enable (ignored while busy) |
| ref_addr | input | 6 | Template pixel index i*8+j |
| ref_data | input | 16 | Template pixel value |
| pix_rd | output | 1 | Live pixel request |
| pix_addr | output | 8 | Live pixel index row*16+col |
| pix_data | input | 16 | Live pixel, valid the cycle after the request |
| busy | output | 1 | Search in progress |
| score_valid | output | 1 | A score is presented this cycle |
| score_idx | output | 7 | Offset index u*9+v of the score |
| score | output | 22 | Sum of absolute differences |
| done | output | 1 | One-cycle pulse after the last score |
| best_u | output | 4 | Row shift of the best match |
| best_v | output | 4 | Column shift of the best match |
| best_score | output | 22 | Smallest score of the search |

## Verification
The bench goes after the edges of the folded schedule. One case is a template cut out of the image at (5,3), which must give an exact zero there. If the shift chain is out of step with the broadcast pixel by even one cycle, that zero is lost and the best offset moves. Saturated images in both directions (bright live over a dark template, and the reverse) catch a subtract that wraps or an accumulator that is too narrow. They also create an 81-way tie that a comparator using less-or-equal would resolve to index 80 instead of 0. A back-to-back repeat of a search, a start and a template write injected mid-search, and the check of all 704 read addresses expose stale accumulators, a restartable sequencer and a last half pass that reads a ninth row past the image edge.

// File: rtl/sadm_pkg.sv
package sadm_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FEED  = 2'd1,
    PH_DRAIN = 2'd2,
    PH_EMIT  = 2'd3
  } phase_e;

  // true when pos lies in [lo, lo+len)
  function automatic logic in_span(int pos, int lo, int len);
    return (pos >= lo) && (pos < lo + len);
  endfunction

  function automatic int div_up(int a, int b);
    return (a + b - 1) / b;
  endfunction

endpackage

// File: rtl/sadm_pe.sv
module sadm_pe
  import sadm_pkg::*;
#(
  parameter int PIX_W   = 16,
  parameter int ACC_W   = 22,
  parameter int TPL     = 8,
  parameter int RW      = 4,
  parameter int CW      = 4,
  parameter int ROW_OFF = 0,
  parameter int COL_OFF = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             act,
  input  logic             bc_vld,
  input  logic [RW-1:0]    bc_r,
  input  logic [CW-1:0]    bc_c,
  input  logic [PIX_W-1:0] bc_pix,
  input  logic [PIX_W-1:0] ref_in,
  output logic [ACC_W-1:0] acc
);

  function automatic logic [PIX_W-1:0] mag(logic [PIX_W-1:0] a, logic [PIX_W-1:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  logic             hit;
  logic             s1_en, s2_en;
  logic [PIX_W-1:0] s1_hi, s1_lo, s2_d;

  assign hit = act && bc_vld &&
               in_span(int'(bc_r), ROW_OFF, TPL) &&
               in_span(int'(bc_c), COL_OFF, TPL);

  // stage 1: order the pair
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_en <= 1'b0;
      s1_hi <= '0;
      s1_lo <= '0;
    end else begin
      s1_en <= hit;
      if (bc_pix >= ref_in) begin
        s1_hi <= bc_pix;
        s1_lo <= ref_in;
      end else begin
        s1_hi <= ref_in;
        s1_lo <= bc_pix;
      end
    end
  end

  // stage 2: non-negative subtract
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_en <= 1'b0;
      s2_d  <= '0;
    end else begin
      s2_en <= s1_en;
      s2_d  <= s1_hi - s1_lo;
    end
  end

  // stage 3: accumulate
  always_ff @(posedge clk) begin
    if (!rst_n)     acc <= '0;
    else if (clr)   acc <= '0;
    else if (s2_en) acc <= acc + ACC_W'(s2_d);
  end

  AST_STAGE_MAG: assert property (@(posedge clk) disable iff (!rst_n)
    s2_en |-> s2_d == mag($past(bc_pix, 2), $past(ref_in, 2))); // R3

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr) |-> acc >= $past(acc)); // R2

endmodule

// File: rtl/sadm_ctrl.sv
module sadm_ctrl
  import sadm_pkg::*;
#(
  parameter int TPL     = 8,
  parameter int IMG     = 16,
  parameter int PE_ROWS = 2,
  parameter int ADDR_W  = 8,
  parameter int RW      = 4,
  parameter int CW      = 4,
  parameter int IDX_W   = 7,
  parameter int KW      = 5,
  parameter int OW      = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  output logic               busy,
  output logic               pix_rd,
  output logic [ADDR_W-1:0]  pix_addr,
  output logic               bc_vld,
  output logic [RW-1:0]      bc_r,
  output logic [CW-1:0]      bc_c,
  output logic               clr,
  output logic [PE_ROWS-1:0] row_act,
  output logic               score_valid,
  output logic [IDX_W-1:0]   score_idx,
  output logic [KW-1:0]      emit_k,
  output logic [OW-1:0]      emit_u,
  output logic [OW-1:0]      emit_v,
  output logic               done
);

  localparam int OFS       = IMG - TPL + 1;
  localparam int NOFF      = OFS * OFS;
  localparam int NPASS     = div_up(OFS, PE_ROWS);
  localparam int PASS_W    = (NPASS > 1) ? $clog2(NPASS) : 1;
  localparam int EA_W      = (PE_ROWS > 1) ? $clog2(PE_ROWS) : 1;
  localparam int DRAIN_CYC = 4;

  phase_e            phase;
  logic [PASS_W-1:0] pass;
  logic [RW-1:0]     fr;
  logic [CW-1:0]     fc;
  logic [2:0]        dcnt;
  logic [EA_W-1:0]   ea;
  logic [OW-1:0]     ev;
  int                u0_i, rows_i, nrow_i;
  logic              feed_end, emit_end, last_pass;

  always_comb begin
    u0_i      = int'(pass) * PE_ROWS;
    rows_i    = (OFS - u0_i >= PE_ROWS) ? PE_ROWS : (OFS - u0_i);
    nrow_i    = TPL + rows_i - 1;
    feed_end  = (int'(fc) == IMG - 1) && (int'(fr) == nrow_i - 1);
    emit_end  = (int'(ev) == OFS - 1) && (int'(ea) == rows_i - 1);
    last_pass = (int'(pass) == NPASS - 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      pass  <= '0;
      fr    <= '0;
      fc    <= '0;
      dcnt  <= '0;
      ea    <= '0;
      ev    <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            phase <= PH_FEED;
            pass  <= '0;
            fr    <= '0;
            fc    <= '0;
          end
        end
        PH_FEED: begin
          if (int'(fc) == IMG - 1) begin
            fc <= '0;
            if (feed_end) begin
              phase <= PH_DRAIN;
              dcnt  <= '0;
            end else begin
              fr <= fr + 1'b1;
            end
          end else begin
            fc <= fc + 1'b1;
          end
        end
        PH_DRAIN: begin
          dcnt <= dcnt + 1'b1;
          if (int'(dcnt) == DRAIN_CYC - 1) begin
            phase <= PH_EMIT;
            ea    <= '0;
            ev    <= '0;
          end
        end
        PH_EMIT: begin
          if (int'(ev) == OFS - 1) begin
            ev <= '0;
            if (emit_end) begin
              if (last_pass) begin
                phase <= PH_IDLE;
                done  <= 1'b1;
              end else begin
                phase <= PH_FEED;
                pass  <= pass + 1'b1;
                fr    <= '0;
                fc    <= '0;
              end
            end else begin
              ea <= ea + 1'b1;
            end
          end else begin
            ev <= ev + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // broadcast registers align coordinates with the returned pixel
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bc_vld <= 1'b0;
      bc_r   <= '0;
      bc_c   <= '0;
    end else begin
      bc_vld <= pix_rd;
      bc_r   <= fr;
      bc_c   <= fc;
    end
  end

  assign busy        = (phase != PH_IDLE);
  assign pix_rd      = (phase == PH_FEED);
  assign pix_addr    = ADDR_W'((u0_i + int'(fr)) * IMG + int'(fc));
  assign clr         = pix_rd && (fr == '0) && (fc == '0);
  assign score_valid = (phase == PH_EMIT);
  assign score_idx   = IDX_W'((u0_i + int'(ea)) * OFS + int'(ev));
  assign emit_k      = KW'(int'(ea) * OFS + int'(ev));
  assign emit_u      = OW'(u0_i + int'(ea));
  assign emit_v      = ev;

  for (genvar a = 0; a < PE_ROWS; a++) begin : g_act
    assign row_act[a] = (u0_i + a < OFS);
  end

  // per-pass read tally for the assertion
  logic [ADDR_W:0] rd_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)      rd_cnt <= '0;
    else if (clr)    rd_cnt <= 1;
    else if (pix_rd) rd_cnt <= rd_cnt + 1'b1;
  end

  AST_PASS_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DRAIN && dcnt == '0) |-> int'(rd_cnt) == nrow_i * IMG); // R4

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    score_valid |-> int'(score_idx) < NOFF); // R1

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (score_valid && $past(score_valid)) |-> score_idx == $past(score_idx) + 1'b1); // R5

  AST_DONE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(score_valid) && int'($past(score_idx)) == NOFF - 1)); // R6

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

endmodule

// File: rtl/sadm_best.sv
module sadm_best #(
  parameter int ACC_W = 22,
  parameter int OW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sv,
  input  logic             first,
  input  logic [OW-1:0]    u,
  input  logic [OW-1:0]    v,
  input  logic [ACC_W-1:0] score,
  output logic [OW-1:0]    best_u,
  output logic [OW-1:0]    best_v,
  output logic [ACC_W-1:0] best_score
);

  // strict less-than keeps the earliest offset on a tie
  function automatic logic better(logic [ACC_W-1:0] cand, logic [ACC_W-1:0] cur);
    return cand < cur;
  endfunction

  logic take;
  assign take = sv && (first || better(score, best_score));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      best_u     <= '0;
      best_v     <= '0;
      best_score <= '0;
    end else if (take) begin
      best_u     <= u;
      best_v     <= v;
      best_score <= score;
    end
  end

  AST_BEST_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sv && !first) |=> best_score <= $past(best_score)); // R7

  AST_BEST_TIE: assert property (@(posedge clk) disable iff (!rst_n)
    (sv && !first && score == best_score) |=> ($stable(best_u) && $stable(best_v))); // R7

endmodule

// File: rtl/sadm_matcher.sv
module sadm_matcher
  import sadm_pkg::*;
#(
  parameter int PIX_W   = 16,
  parameter int TPL     = 8,
  parameter int IMG     = 16,
  parameter int PE_ROWS = 2,
  parameter int RADDR_W = $clog2(TPL * TPL),
  parameter int ADDR_W  = $clog2(IMG * IMG),
  parameter int ACC_W   = PIX_W + $clog2(TPL * TPL),
  parameter int IDX_W   = $clog2((IMG - TPL + 1) * (IMG - TPL + 1)),
  parameter int OW      = $clog2(IMG - TPL + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               ref_we,
  input  logic [RADDR_W-1:0] ref_addr,
  input  logic [PIX_W-1:0]   ref_data,
  output logic               pix_rd,
  output logic [ADDR_W-1:0]  pix_addr,
  input  logic [PIX_W-1:0]   pix_data,
  output logic               busy,
  output logic               score_valid,
  output logic [IDX_W-1:0]   score_idx,
  output logic [ACC_W-1:0]   score,
  output logic               done,
  output logic [OW-1:0]      best_u,
  output logic [OW-1:0]      best_v,
  output logic [ACC_W-1:0]   best_score
);

  localparam int OFS = IMG - TPL + 1;
  localparam int NPE = PE_ROWS * OFS;
  localparam int KW  = $clog2(NPE);
  localparam int RW  = $clog2(TPL + PE_ROWS);
  localparam int CW  = $clog2(IMG);

  logic                 bc_vld, clr;
  logic [RW-1:0]        bc_r;
  logic [CW-1:0]        bc_c;
  logic [PE_ROWS-1:0]   row_act;
  logic [KW-1:0]        emit_k;
  logic [OW-1:0]        emit_u, emit_v;
  logic [NPE*ACC_W-1:0] acc_flat;
  logic [PIX_W-1:0]     tpl_mem [TPL*TPL];

  // template store, writable only while idle
  always_ff @(posedge clk) begin
    if (ref_we && !busy) tpl_mem[ref_addr] <= ref_data;
  end

  sadm_ctrl #(
    .TPL(TPL), .IMG(IMG), .PE_ROWS(PE_ROWS), .ADDR_W(ADDR_W),
    .RW(RW), .CW(CW), .IDX_W(IDX_W), .KW(KW), .OW(OW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .pix_rd(pix_rd), .pix_addr(pix_addr),
    .bc_vld(bc_vld), .bc_r(bc_r), .bc_c(bc_c), .clr(clr),
    .row_act(row_act), .score_valid(score_valid), .score_idx(score_idx),
    .emit_k(emit_k), .emit_u(emit_u), .emit_v(emit_v), .done(done)
  );

  for (genvar a = 0; a < PE_ROWS; a++) begin : g_row
    logic [PIX_W-1:0]           head;
    logic [(OFS-1)*PIX_W-1:0]   chain;
    int                         ti, tj;

    // template pixel entering the chain for this placement row
    always_comb begin
      ti   = int'(bc_r) - a;
      tj   = int'(bc_c);
      head = '0;
      if (in_span(ti, 0, TPL) && in_span(tj, 0, TPL))
        head = tpl_mem[RADDR_W'(ti * TPL + tj)];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[(OFS-1)*PIX_W-1-PIX_W:0], head};
    end

    for (genvar v = 0; v < OFS; v++) begin : g_col
      logic [PIX_W-1:0] tap;
      if (v == 0) begin : g_head
        assign tap = head;
      end else begin : g_tail
        assign tap = chain[(v-1)*PIX_W +: PIX_W];
      end

      sadm_pe #(
        .PIX_W(PIX_W), .ACC_W(ACC_W), .TPL(TPL), .RW(RW), .CW(CW),
        .ROW_OFF(a), .COL_OFF(v)
      ) u_pe (
        .clk(clk), .rst_n(rst_n), .clr(clr), .act(row_act[a]),
        .bc_vld(bc_vld), .bc_r(bc_r), .bc_c(bc_c), .bc_pix(pix_data),
        .ref_in(tap), .acc(acc_flat[(a*OFS+v)*ACC_W +: ACC_W])
      );
    end
  end

  assign score = acc_flat[int'(emit_k)*ACC_W +: ACC_W];

  sadm_best #(.ACC_W(ACC_W), .OW(OW)) u_best (
    .clk(clk), .rst_n(rst_n), .sv(score_valid), .first(score_idx == '0),
    .u(emit_u), .v(emit_v), .score(score),
    .best_u(best_u), .best_v(best_v), .best_score(best_score)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!pix_rd && !score_valid)); // R9

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy && pix_rd && $past(pix_rd)) |-> pix_addr != '0); // R9

endmodule

// File: tb/sim_sadm_matcher.sv
module sim_sadm_matcher;

  localparam int CLK_NS = 10;
  localparam int NOFF   = 81;
  localparam int NREAD  = 704;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        ref_we = 1'b0;
  logic [5:0]  ref_addr = '0;
  logic [15:0] ref_data = '0;
  logic        pix_rd;
  logic [7:0]  pix_addr;
  logic [15:0] pix_data = '0;
  logic        busy, score_valid, done;
  logic [6:0]  score_idx;
  logic [21:0] score, best_score;
  logic [3:0]  best_u, best_v;

  always #(CLK_NS/2) clk = ~clk;

  sadm_matcher u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_we(ref_we),
    .ref_addr(ref_addr), .ref_data(ref_data), .pix_rd(pix_rd),
    .pix_addr(pix_addr), .pix_data(pix_data), .busy(busy),
    .score_valid(score_valid), .score_idx(score_idx), .score(score),
    .done(done), .best_u(best_u), .best_v(best_v), .best_score(best_score)
  );

  int img [256];
  int tpl [64];
  int exp_s [NOFF];
  int exp_bu, exp_bv, exp_bs;

  // external image buffer: data one cycle after request
  always @(posedge clk) if (pix_rd) pix_data <= 16'(img[pix_addr]);

  int n_vec = 0, n_fail = 0;
  int m_vec = 0, m_fail = 0;
  int rd_n = 0, sc_n = 0, done_n = 0;

  function automatic int exp_addr(int n);
    int k = n % NREAD;
    for (int p = 0; p < 5; p++) begin
      int rows = (2*p + 1 < 9) ? 9 : 8;
      if (k < rows*16) return (2*p + k/16)*16 + k%16;
      k -= rows*16;
    end
    return -1;
  endfunction

  // monitor: read addresses, score stream, done pulses
  always @(negedge clk) begin
    if (rst_n) begin
      if (pix_rd) begin
        m_vec++;
        if (int'(pix_addr) != exp_addr(rd_n)) begin
          m_fail++;
          $display("FAIL R4 read %0d addr act=%0d exp=%0d", rd_n, pix_addr, exp_addr(rd_n));
        end
        rd_n++;
      end
      if (score_valid) begin
        m_vec++;
        if (int'(score_idx) != sc_n % NOFF) begin
          m_fail++;
          $display("FAIL R5 order act=%0d exp=%0d", score_idx, sc_n % NOFF);
        end else if (int'(score) != exp_s[score_idx]) begin
          m_fail++;
          $display("FAIL R1 score idx %0d act=%0d exp=%0d", score_idx, score, exp_s[score_idx]);
        end
        sc_n++;
      end
      if (done) begin
        m_vec++;
        if (sc_n % NOFF != 0) begin
          m_fail++;
          $display("FAIL R6 done after score count act=%0d exp=%0d", sc_n % NOFF, 0);
        end
        done_n++;
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int expv);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, expv);
    end
  endtask

  task automatic compute_expect();
    exp_bs = -1;
    for (int u = 0; u < 9; u++) begin
      for (int v = 0; v < 9; v++) begin
        int s = 0;
        for (int i = 0; i < 8; i++)
          for (int j = 0; j < 8; j++) begin
            int d = img[(i+u)*16 + j+v] - tpl[i*8+j];
            s += (d < 0) ? -d : d;
          end
        exp_s[u*9+v] = s;
        if (exp_bs < 0 || s < exp_bs) begin
          exp_bs = s; exp_bu = u; exp_bv = v;
        end
      end
    end
  endtask

  task automatic run_case(string name, bit load, bit poke);
    int rd0 = rd_n, sc0 = sc_n, dn0 = done_n, cyc = 0;
    compute_expect();
    if (load) begin
      for (int k = 0; k < 64; k++) begin
        @(negedge clk);
        ref_we = 1'b1; ref_addr = 6'(k); ref_data = 16'(tpl[k]);
      end
      @(negedge clk);
      ref_we = 1'b0;
    end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, {"R9 busy after start ", name}, busy, 1);
    if (poke) begin
      repeat (60) @(negedge clk);
      start = 1'b1; ref_we = 1'b1; ref_addr = 6'd0; ref_data = ~16'(tpl[0]);
      @(negedge clk);
      start = 1'b0; ref_we = 1'b0;
    end
    while (done_n == dn0 && cyc < 6000) begin
      @(negedge clk); cyc++;
    end
    chk(cyc < 6000, {"R6 watchdog ", name}, cyc, 6000);
    repeat (8) @(negedge clk);
    chk(rd_n - rd0 == NREAD, {"R4 read count ", name}, rd_n - rd0, NREAD);
    chk(sc_n - sc0 == NOFF, {"R1 score count ", name}, sc_n - sc0, NOFF);
    chk(done_n - dn0 == 1, {"R6 done count ", name}, done_n - dn0, 1);
    chk(busy == 1'b0, {"R9 idle after ", name}, busy, 0);
    chk(int'(best_score) == exp_bs, {"R7 best score ", name}, best_score, exp_bs);
    chk(int'(best_u) == exp_bu, {"R7 best u ", name}, best_u, exp_bu);
    chk(int'(best_v) == exp_bv, {"R7 best v ", name}, best_v, exp_bv);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0, "R9 reset busy", busy, 0);
    chk(score_valid == 0, "R9 reset score_valid", score_valid, 0);
    chk(done == 0, "R9 reset done", done, 0);
    chk(pix_rd == 0, "R9 reset pix_rd", pix_rd, 0);

    // R1 R3 R8 R9: mixed data, start and template write poked mid-search
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++)
        img[r*16+c] = (r*4099 + c*257 + r*c*61) % 65536;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        tpl[i*8+j] = (i*913 + j*3001 + 77) % 65536;
    run_case("mixed", 1'b1, 1'b1);
    // R10 R8: repeat without reloading the template
    run_case("repeat", 1'b0, 1'b0);

    // R7: template cut from the image at (5,3)
    for (int r = 0; r < 16; r++)
      for (int c = 0; c < 16; c++)
        img[r*16+c] = (r*r*29 + c*c*17 + r*c*3) % 4096;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        tpl[i*8+j] = img[(i+5)*16 + j+3];
    run_case("embed", 1'b1, 1'b0);
    chk(best_score == 0, "R7 embedded exact match", best_score, 0);

    // R2 R7: bright image over dark template, full tie
    for (int k = 0; k < 256; k++) img[k] = 65535;
    for (int k = 0; k < 64; k++) tpl[k] = 0;
    run_case("sat_hi", 1'b1, 1'b0);
    chk(best_score == 22'd4194240, "R2 full-scale sum", best_score, 4194240);
    chk(best_u == 0 && best_v == 0, "R7 tie keeps index 0", {best_u, best_v}, 0);

    // R3: dark image under bright template gives same magnitude
    for (int k = 0; k < 256; k++) img[k] = 0;
    for (int k = 0; k < 64; k++) tpl[k] = 65535;
    run_case("sat_lo", 1'b1, 1'b0);
    chk(best_score == 22'd4194240, "R3 symmetric difference", best_score, 4194240);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec + m_vec, n_fail + m_fail);
    $finish;
  end

endmodule